// File: doc/BRIEF.md
# Stacked-Band Multicarrier PWM Modulator

This block produces the gate commands for one phase leg of an odd-level cascaded H-bridge inverter. The voltage range is split into 2·N equal bands, N above zero and N below it. Each band carries its own triangular carrier. On every sample strobe the block compares a signed reference sample against all of these carriers, adds the comparison votes into a signed output level between −N and +N, and turns that level into on/off commands for N series H-bridge cells. The carriers can run all in phase, mirrored across zero, or mirrored band by band. A two-bit mode input picks the arrangement.

The carrier is one triangle counter that moves one step per accepted sample. It rises from 0 to `CAR_MAX` and falls back, so one full period takes 2·`CAR_MAX` strobes. Each band places this triangle, or its mirror image (`CAR_MAX` minus the count), on top of its band floor. Because the mirror is applied as the value is read, a change of mode takes effect at the very next sample, with no restart. Sine generation, dead-time insertion and capacitor balancing are done outside the block.

Top module: `mlpwm_modulator`

## Requirements
- R1: Band b (0 = lowest) spans [(b−N)·CAR_MAX, (b−N+1)·CAR_MAX]. A band at or above zero (b ≥ N) adds +1 to the level when the reference is greater than or equal to its carrier, and 0 otherwise.
- R2: A band below zero (b < N) adds −1 when the reference is strictly less than its carrier, and 0 otherwise. The output level is the sum of all 2·N votes.
- R3: A reference above N·CAR_MAX gives level +N. A reference below −N·CAR_MAX gives level −N.
- R4: The triangle count t starts at 0 and rises first after reset. It changes by exactly one per strobe, turns at 0 and at CAR_MAX, and so repeats every 2·CAR_MAX strobes. A band's carrier is its floor plus t, or its floor plus (CAR_MAX − t) when the band is mirrored.
- R5: With mode code 0 no band is mirrored.
- R6: With mode code 1 every band below zero is mirrored and every band above zero is not.
- R7: With mode code 2 the first band above zero is not mirrored, and the mirroring alternates from band to band.
- R8: Mode code 3 behaves exactly like mode code 0.
- R9: Cell i (0-based) is positive when the level is greater than i, negative when the level is less than −i, and zero otherwise. Each cell uses 4 bits of `gate_out` starting at bit 4·i, in the order hi1, lo1, hi2, lo2. Positive is 1,0,1,0. Zero is 0,1,1,0. Negative is 0,1,0,1.
- R10: Within any cell, hi1 and lo1 are never both 1, and hi2 and lo2 are never both 1.
- R11: Level and gates take the result of a strobe one clock after it. Both hold their values in cycles with no strobe.
- R12: Synchronous reset sets the triangle count to 0 and rising, the level to 0, and every cell to the zero state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_valid | input | 1 | Strobe: compare, update the outputs, step the carrier |
| ref_sample | input | REF_W | Signed reference sample |
| disp_mode | input | 2 | Carrier arrangement: 0 in phase, 1 mirrored across zero, 2 alternating, 3 same as 0 |
| level_out | output | LVL_W | Signed output level, −N..+N |
| gate_out | output | 4·N_POS | Switch commands, 4 bits per cell |

## Verification
The assertions assume that `sample_valid` is either 0 or 1 on every edge after reset. They also assume that `disp_mode` is settled at each strobe. `CAR_MAX` must be at least 2, so that the triangle can turn. `REF_W` must be wide enough to hold references beyond ±N·CAR_MAX. The stimulus changes the reference and the mode only on the falling clock edge. It keeps the strobe to single-cycle pulses and applies each new mode under reset. It sweeps references a few steps past both ends of the carrier stack, so that saturation is reached without exceeding the reference width.

// File: rtl/mlpwm_pkg.sv
package mlpwm_pkg;

    typedef enum logic [1:0] {
        MODE_INPHASE = 2'd0,
        MODE_SPLIT   = 2'd1,
        MODE_ALT     = 2'd2,
        MODE_SPARE   = 2'd3
    } disp_mode_e;

    typedef enum logic [1:0] {
        CELL_ZERO = 2'd0,
        CELL_POS  = 2'd1,
        CELL_NEG  = 2'd2
    } cell_state_e;

    // bit 0 = hi1, bit 1 = lo1, bit 2 = hi2, bit 3 = lo2
    typedef struct packed {
        logic lo2;
        logic hi2;
        logic lo1;
        logic hi1;
    } cell_gates_t;

    // Whether a band reads the triangle mirrored (CAR_MAX - t)
    function automatic logic band_mirrored(input disp_mode_e m, input int band, input int npos);
        case (m)
            MODE_SPLIT: return (band < npos);
            MODE_ALT:   return (((band + npos) % 2) == 1);
            default:    return 1'b0;
        endcase
    endfunction

    function automatic cell_gates_t gates_of(input cell_state_e s);
        cell_gates_t g;
        case (s)
            CELL_POS: g = '{lo2: 1'b0, hi2: 1'b1, lo1: 1'b0, hi1: 1'b1};
            CELL_NEG: g = '{lo2: 1'b1, hi2: 1'b0, lo1: 1'b1, hi1: 1'b0};
            default:  g = '{lo2: 1'b0, hi2: 1'b1, lo1: 1'b1, hi1: 1'b0};
        endcase
        return g;
    endfunction

endpackage

// File: rtl/tri_counter.sv
module tri_counter #(
    parameter int CAR_MAX = 8,
    localparam int CNT_W  = $clog2(CAR_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    output logic [CNT_W-1:0] cnt
);
    logic rising;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            rising <= 1'b1;
        end else if (step) begin
            if (rising) begin
                cnt <= cnt + 1'b1;
                if (cnt == CNT_W'(CAR_MAX - 1)) rising <= 1'b0;
            end else begin
                cnt <= cnt - 1'b1;
                if (cnt == CNT_W'(1)) rising <= 1'b1;
            end
        end
    end

    a_r4_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_W'(CAR_MAX));

    a_r4_unit_step: assert property (@(posedge clk) disable iff (rst)
        step |=> (cnt == CNT_W'($past(cnt) + 1'b1)) || (cnt == CNT_W'($past(cnt) - 1'b1)));

    a_r4_turn_top: assert property (@(posedge clk) disable iff (rst)
        (step && cnt == CNT_W'(CAR_MAX)) |=> cnt == CNT_W'(CAR_MAX - 1));

    a_r4_turn_bottom: assert property (@(posedge clk) disable iff (rst)
        (step && cnt == '0) |=> cnt == CNT_W'(1));

    a_r11_cnt_hold: assert property (@(posedge clk) disable iff (rst)
        !step |=> $stable(cnt));

endmodule

// File: rtl/band_slicer.sv
module band_slicer
    import mlpwm_pkg::*;
#(
    parameter int N_POS   = 2,
    parameter int CAR_MAX = 8,
    parameter int REF_W   = 8,
    parameter int BAND    = 0,
    localparam int CNT_W  = $clog2(CAR_MAX + 1)
) (
    input  logic signed [REF_W-1:0] ref_in,
    input  logic        [CNT_W-1:0] cnt,
    input  disp_mode_e              mode,
    output logic signed [1:0]       vote
);
    localparam int FLOOR = (BAND - N_POS) * CAR_MAX;

    int carrier;
    int r;

    always_comb begin
        r = int'(ref_in);
        if (band_mirrored(mode, BAND, N_POS))
            carrier = FLOOR + CAR_MAX - int'(cnt);
        else
            carrier = FLOOR + int'(cnt);
    end

    generate
        if (BAND >= N_POS) begin : g_upper
            always_comb vote = (r >= carrier) ? 2'sd1 : 2'sd0;
        end else begin : g_lower
            always_comb vote = (r < carrier) ? -2'sd1 : 2'sd0;
        end
    endgenerate

endmodule

// File: rtl/cell_mapper.sv
module cell_mapper
    import mlpwm_pkg::*;
#(
    parameter int N_POS  = 2,
    parameter int LVL_W  = 3
) (
    input  logic signed [LVL_W-1:0] level,
    output logic [4*N_POS-1:0]      gates
);
    cell_state_e st [N_POS];

    generate
        for (genvar i = 0; i < N_POS; i++) begin : g_cell
            always_comb begin
                if (int'(level) > i)       st[i] = CELL_POS;
                else if (int'(level) < -i) st[i] = CELL_NEG;
                else                       st[i] = CELL_ZERO;
                gates[4*i +: 4] = gates_of(st[i]);
            end
        end
    endgenerate

endmodule

// File: rtl/mlpwm_modulator.sv
module mlpwm_modulator
    import mlpwm_pkg::*;
#(
    parameter int N_POS   = 2,
    parameter int CAR_MAX = 8,
    parameter int REF_W   = 8,
    localparam int NBANDS = 2 * N_POS,
    localparam int CNT_W  = $clog2(CAR_MAX + 1),
    localparam int LVL_W  = $clog2(N_POS + 1) + 1,
    localparam int GATE_W = 4 * N_POS
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    sample_valid,
    input  logic signed [REF_W-1:0] ref_sample,
    input  logic [1:0]              disp_mode,
    output logic signed [LVL_W-1:0] level_out,
    output logic [GATE_W-1:0]       gate_out
);
    disp_mode_e              mode;
    logic [CNT_W-1:0]        tri_cnt;
    logic signed [1:0]       votes [NBANDS];
    logic signed [LVL_W-1:0] level_next;
    logic [GATE_W-1:0]       gates_next;
    logic [GATE_W-1:0]       gates_idle;

    assign mode = disp_mode_e'(disp_mode);

    tri_counter #(.CAR_MAX(CAR_MAX)) u_tri (
        .clk  (clk),
        .rst  (rst),
        .step (sample_valid),
        .cnt  (tri_cnt)
    );

    generate
        for (genvar b = 0; b < NBANDS; b++) begin : g_band
            band_slicer #(
                .N_POS   (N_POS),
                .CAR_MAX (CAR_MAX),
                .REF_W   (REF_W),
                .BAND    (b)
            ) u_slice (
                .ref_in (ref_sample),
                .cnt    (tri_cnt),
                .mode   (mode),
                .vote   (votes[b])
            );
        end
    endgenerate

    always_comb begin
        int acc;
        acc = 0;
        for (int b = 0; b < NBANDS; b++) acc += int'(votes[b]);
        level_next = LVL_W'(acc);
    end

    cell_mapper #(.N_POS(N_POS), .LVL_W(LVL_W)) u_map (
        .level (level_next),
        .gates (gates_next)
    );

    always_comb begin
        for (int i = 0; i < N_POS; i++) gates_idle[4*i +: 4] = gates_of(CELL_ZERO);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            level_out <= '0;
            gate_out  <= gates_idle;
        end else if (sample_valid) begin
            level_out <= level_next;
            gate_out  <= gates_next;
        end
    end

    // Assertion support: net cell contribution decoded from the gate bus
    function automatic int gate_sum(input logic [GATE_W-1:0] g);
        int s;
        s = 0;
        for (int i = 0; i < N_POS; i++) begin
            if (g[4*i] && g[4*i+2]) s += 1;
            else if (g[4*i+1] && g[4*i+3]) s -= 1;
        end
        return s;
    endfunction

    a_r3_level_range: assert property (@(posedge clk) disable iff (rst)
        (int'(level_out) <= N_POS) && (int'(level_out) >= -N_POS));

    a_r9_cells_match_level: assert property (@(posedge clk) disable iff (rst)
        gate_sum(gate_out) == int'(level_out));

    a_r11_hold_outputs: assert property (@(posedge clk) disable iff (rst)
        !sample_valid |=> ($stable(level_out) && $stable(gate_out)));

    a_r12_reset_idle: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (level_out == '0 && gate_out == gates_idle));

    generate
        for (genvar i = 0; i < N_POS; i++) begin : g_leg_chk
            a_r10_legs_exclusive: assert property (@(posedge clk) disable iff (rst)
                !(gate_out[4*i] && gate_out[4*i+1]) && !(gate_out[4*i+2] && gate_out[4*i+3]));
        end
    endgenerate

endmodule

// File: tb/tb_mlpwm_modulator.sv
module tb_mlpwm_modulator;
    localparam int N_POS   = 2;
    localparam int CAR_MAX = 8;
    localparam int REF_W   = 8;
    localparam int LVL_W   = 3;
    localparam int GATE_W  = 4 * N_POS;
    localparam int SPAN    = N_POS * CAR_MAX;

    logic                    clk = 1'b0;
    logic                    rst;
    logic                    sample_valid;
    logic signed [REF_W-1:0] ref_sample;
    logic [1:0]              disp_mode;
    logic signed [LVL_W-1:0] level_out;
    logic [GATE_W-1:0]       gate_out;

    int n_checks = 0;
    int n_fail   = 0;
    int phase_k  = 0;

    always #5 clk = ~clk;

    mlpwm_modulator #(.N_POS(N_POS), .CAR_MAX(CAR_MAX), .REF_W(REF_W)) dut (
        .clk          (clk),
        .rst          (rst),
        .sample_valid (sample_valid),
        .ref_sample   (ref_sample),
        .disp_mode    (disp_mode),
        .level_out    (level_out),
        .gate_out     (gate_out)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int tri_at(input int k);
        int p;
        p = k % (2 * CAR_MAX);
        return (p <= CAR_MAX) ? p : 2 * CAR_MAX - p;
    endfunction

    function automatic int exp_level(input int r, input int md, input int k);
        int t, s, c;
        bit mir;
        t = tri_at(k);
        s = 0;
        for (int b = 0; b < 2 * N_POS; b++) begin
            if (md == 1)      mir = (b < N_POS);
            else if (md == 2) mir = (((b - N_POS) % 2) != 0);
            else              mir = 1'b0;
            c = (b - N_POS) * CAR_MAX + (mir ? CAR_MAX - t : t);
            if (b >= N_POS) begin
                if (r >= c) s++;
            end else begin
                if (r < c) s--;
            end
        end
        return s;
    endfunction

    function automatic int exp_gates(input int lvl);
        int g;
        g = 0;
        for (int i = 0; i < N_POS; i++) begin
            if (lvl > i)       g |= 4'b0101 << (4 * i);
            else if (lvl < -i) g |= 4'b1010 << (4 * i);
            else               g |= 4'b0110 << (4 * i);
        end
        return g;
    endfunction

    task automatic do_reset(input int md);
        @(negedge clk);
        rst = 1'b1;
        sample_valid = 1'b0;
        disp_mode = 2'(md);
        repeat (2) @(negedge clk);
        rst = 1'b0;
        phase_k = 0;
        check("R12 level after reset", int'(level_out), 0);
        check("R12 gates after reset", int'(gate_out), exp_gates(0));
    endtask

    task automatic strobe(input int r);
        @(negedge clk);
        ref_sample = REF_W'(r);
        sample_valid = 1'b1;
        @(negedge clk);
        sample_valid = 1'b0;
    endtask

    initial begin
        rst = 1'b1;
        sample_valid = 1'b0;
        ref_sample = '0;
        disp_mode = 2'd0;
        for (int md = 0; md < 4; md++) begin
            string tag;
            int e;
            case (md)
                0: tag = "R1 R2 R4 R5";
                1: tag = "R1 R2 R4 R6";
                2: tag = "R1 R2 R4 R7";
                default: tag = "R1 R2 R4 R8";
            endcase
            do_reset(md);
            for (int r = -SPAN - 4; r <= SPAN + 4; r++) begin
                for (int s = 0; s < 2 * CAR_MAX; s++) begin
                    strobe(r);
                    e = exp_level(r, md, phase_k);
                    if (r > SPAN || r < -SPAN)
                        check("R3 saturated level", int'(level_out), (r > 0) ? N_POS : -N_POS);
                    check(tag, int'(level_out), e);
                    check("R9 gate pattern", int'(gate_out), exp_gates(e));
                    for (int i = 0; i < N_POS; i++) begin
                        check("R10 leg1 exclusive", int'(gate_out[4*i] & gate_out[4*i+1]), 0);
                        check("R10 leg2 exclusive", int'(gate_out[4*i+2] & gate_out[4*i+3]), 0);
                    end
                    phase_k++;
                end
            end
            // R11: no strobe -> outputs hold while the reference moves
            begin
                int held_lvl, held_g;
                held_lvl = int'(level_out);
                held_g = int'(gate_out);
                for (int j = 0; j < 3; j++) begin
                    @(negedge clk);
                    ref_sample = REF_W'((j % 2 == 0) ? SPAN : -SPAN);
                end
                @(negedge clk);
                check("R11 level hold", int'(level_out), held_lvl);
                check("R11 gates hold", int'(gate_out), held_g);
                strobe(SPAN + 1);
                check("R11 one-cycle update", int'(level_out), N_POS);
                phase_k++;
            end
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #1500000;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule